// File: doc/BRIEF.md
# PHY Link Poller and Port Override Sequencer

This block keeps the per-port state of a small Ethernet switch in step with the PHYs attached to it. A command starts a sweep over the ports. For each port, the block asks the management-bus master for PHY register reads, one read at a time. It works out whether the link came up or went down, and for a link that came up it works out the speed and duplex. It then issues byte writes into the switch's per-port override and traffic-control registers. Ports marked as bypass are never read. They get a fixed override built from their configuration inputs.

There are two commands. A `start` pulse performs a full bring-up in three steps. First it marks every port down and disabled. Then it applies the overrides for bypass ports. Last it runs one polling sweep. A `poll_req` pulse runs only the polling sweep and keeps the link state remembered from earlier sweeps, so a link that drops is noticed and its port is shut. The serial wire protocol of the management bus lives outside this block.

Top module: `link_poller`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `mreq_valid` are low, and `link_up` is all zeros.
- R2: On `start`, before any other write, the block visits ports 0 to NPORTS-1 in ascending order. For each port it writes the override byte 0x40 (enable bit 6 only) and then the traffic byte 0x03 (bit0 RX disable, bit1 TX disable). Every stored link state is cleared.
- R3: An enabled bypass port is never read. After the start clearing, it is written override = 0x41 | speed | (force_fdx ? 0x02 : 0), then traffic 0x00. Its 2-bit speed code selects the speed bit: 00 = 10 Mb/s (no bit), 01 = 100 Mb/s (bit2, 0x04), 10 = 1000 Mb/s (bit3, 0x08), 11 = no speed bit. A disabled port is never read and never written after the clearing.
- R4: For each polled port, basic status (register 1) is read twice and only the second value is used. A second value of 0xFFFF skips the port with no write.
- R5: A port is acted on only when bit2 of the second status value differs from its stored link state. The stored state, visible on `link_up`, then takes the new value. An unchanged state produces no write.
- R6: On a transition to down, the block writes override 0x40 and then traffic 0x03.
- R7: On a transition to up, it reads register 4 (local advertisement) and register 5 (partner ability) and takes their AND. In falling priority, bit8 means 100 full, bit7 means 100 half and bit6 means 10 full; with none of these set the result is 10 half.
- R8: When bit8 of the status value is set, the block also reads register 9 (bit9 and bit8 are the local gigabit abilities) and register 10 (bit11 and bit10 are the partner's gigabit full and half abilities). When a local bit and a partner bit are both set, the result is 1000 Mb/s, with duplex taken from register 10 bit11.
- R9: On a transition to up, the block writes override = 0x41 | speed bit | (full ? 0x02 : 0), then traffic 0x00.
- R10: `mreq_ext` is high for reads on behalf of ports 4 and above, and low for ports below 4.
- R11: A read request is high for exactly one cycle. The next request waits for `mrsp_valid`, so at most one read is outstanding.
- R12: `done` pulses for one cycle after the last write of a sweep. `poll_req` runs the polling sweep alone and keeps the stored link states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Full bring-up pulse (clear, bypass, poll) |
| poll_req | input | 1 | Poll-only pulse |
| port_en | input | 8 | Port is in use |
| port_bypass | input | 8 | Port takes forced settings instead of polling |
| force_spd | input | 16 | 2-bit forced speed code per port |
| force_fdx | input | 8 | Forced full duplex per port |
| phy_addr | input | 40 | 5-bit PHY address per port |
| mreq_valid | output | 1 | Management read request |
| mreq_ext | output | 1 | Request targets the external bus |
| mreq_phy | output | 5 | PHY address of the request |
| mreq_reg | output | 5 | PHY register number of the request |
| mrsp_valid | input | 1 | Read data is valid |
| mrsp_data | input | 16 | Read data |
| wr_en | output | 1 | Byte write strobe |
| wr_ovr | output | 1 | 1 = override byte, 0 = traffic byte |
| wr_port | output | 3 | Port the write targets |
| wr_data | output | 8 | Byte written |
| link_up | output | 8 | Stored link state per port |
| busy | output | 1 | A sweep is running |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The assertions take two things for granted about the inputs. `mrsp_valid` answers only a request that is still outstanding. `start` and `poll_req` pulses arrive only while the block is idle. The bench's PHY model replies once per request, after a latency that varies from one to four cycles. The bench raises a command only after the `done` of the previous sweep. The model returns a different first status value than second, so any use of the first read changes the written bytes.

// File: rtl/link_poller.sv
module link_poller #(
  parameter int NPORTS    = 8,
  parameter int AW        = 5,
  parameter int EXT_FIRST = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 poll_req,
  input  logic [NPORTS-1:0]    port_en,
  input  logic [NPORTS-1:0]    port_bypass,
  input  logic [2*NPORTS-1:0]  force_spd,
  input  logic [NPORTS-1:0]    force_fdx,
  input  logic [AW*NPORTS-1:0] phy_addr,
  output logic                 mreq_valid,
  output logic                 mreq_ext,
  output logic [AW-1:0]        mreq_phy,
  output logic [4:0]           mreq_reg,
  input  logic                 mrsp_valid,
  input  logic [15:0]          mrsp_data,
  output logic                 wr_en,
  output logic                 wr_ovr,
  output logic [PW-1:0]        wr_port,
  output logic [7:0]           wr_data,
  output logic [NPORTS-1:0]    link_up,
  output logic                 busy,
  output logic                 done
);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_REQ, S_WAIT, S_WO, S_WT, S_DONE} st_t;
  typedef enum logic [1:0] {PH_INIT, PH_BYP, PH_POLL} ph_t;

  st_t             state, nxt_state;
  ph_t             phase, nxt_phase;
  logic [PW-1:0]   port, nxt_port;
  logic [2:0]      step;
  logic [NPORTS-1:0] link;
  logic [7:0]      ovr_q, tc_q;
  logic [15:0]     bmsr_q, adv_q, c1k_q;
  logic [1:0]      spd_q, res_spd;
  logic            fdx_q, res_fdx;
  logic [15:0]     media;
  logic            gig, last;

  function automatic logic [7:0] ovr_up(input logic [1:0] spd, input logic fdx);
    logic [7:0] v;
    v = 8'h41;
    if (spd == 2'd2) v = v | 8'h08;
    else if (spd == 2'd1) v = v | 8'h04;
    v[1] = fdx;
    return v;
  endfunction

  assign media = adv_q & mrsp_data;
  assign gig   = (c1k_q[9] | c1k_q[8]) & (mrsp_data[11] | mrsp_data[10]);

  always_comb begin
    if (media[8])      begin res_spd = 2'd1; res_fdx = 1'b1; end
    else if (media[7]) begin res_spd = 2'd1; res_fdx = 1'b0; end
    else if (media[6]) begin res_spd = 2'd0; res_fdx = 1'b1; end
    else               begin res_spd = 2'd0; res_fdx = 1'b0; end
  end

  always_comb begin
    last      = (port == PW'(NPORTS - 1));
    nxt_port  = last ? '0 : port + 1'b1;
    nxt_phase = phase;
    if (last) nxt_phase = (phase == PH_INIT) ? PH_BYP : PH_POLL;
    nxt_state = (last && phase == PH_POLL) ? S_DONE : S_CHK;
  end

  always_comb begin
    case (step)
      3'd0, 3'd1: mreq_reg = 5'd1;
      3'd2:       mreq_reg = 5'd4;
      3'd3:       mreq_reg = 5'd5;
      3'd4:       mreq_reg = 5'd9;
      default:    mreq_reg = 5'd10;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= PH_INIT; port <= '0; step <= '0; link <= '0;
      ovr_q <= '0; tc_q <= '0; bmsr_q <= '0; adv_q <= '0; c1k_q <= '0;
      spd_q <= '0; fdx_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            link <= '0; phase <= PH_INIT; port <= '0; state <= S_CHK;
          end else if (poll_req) begin
            phase <= PH_POLL; port <= '0; state <= S_CHK;
          end
        end
        S_CHK: begin
          if (phase == PH_INIT) begin
            ovr_q <= 8'h40; tc_q <= 8'h03; state <= S_WO;
          end else if (phase == PH_BYP) begin
            if (port_en[port] && port_bypass[port]) begin
              ovr_q <= ovr_up(force_spd[2*port +: 2], force_fdx[port]);
              tc_q <= 8'h00; state <= S_WO;
            end else begin
              port <= nxt_port; phase <= nxt_phase; state <= nxt_state;
            end
          end else begin
            if (port_en[port] && !port_bypass[port]) begin
              step <= 3'd0; state <= S_REQ;
            end else begin
              port <= nxt_port; phase <= nxt_phase; state <= nxt_state;
            end
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: begin
          if (mrsp_valid) begin
            case (step)
              3'd0: begin step <= 3'd1; state <= S_REQ; end
              3'd1: begin
                bmsr_q <= mrsp_data;
                if (mrsp_data == 16'hFFFF || mrsp_data[2] == link[port]) begin
                  port <= nxt_port; phase <= nxt_phase; state <= nxt_state;
                end else begin
                  link[port] <= mrsp_data[2];
                  if (!mrsp_data[2]) begin
                    ovr_q <= 8'h40; tc_q <= 8'h03; state <= S_WO;
                  end else begin
                    step <= 3'd2; state <= S_REQ;
                  end
                end
              end
              3'd2: begin adv_q <= mrsp_data; step <= 3'd3; state <= S_REQ; end
              3'd3: begin
                if (bmsr_q[8]) begin
                  spd_q <= res_spd; fdx_q <= res_fdx; step <= 3'd4; state <= S_REQ;
                end else begin
                  ovr_q <= ovr_up(res_spd, res_fdx); tc_q <= 8'h00; state <= S_WO;
                end
              end
              3'd4: begin c1k_q <= mrsp_data; step <= 3'd5; state <= S_REQ; end
              default: begin
                ovr_q <= gig ? ovr_up(2'd2, mrsp_data[11]) : ovr_up(spd_q, fdx_q);
                tc_q <= 8'h00; state <= S_WO;
              end
            endcase
          end
        end
        S_WO: state <= S_WT;
        S_WT: begin port <= nxt_port; phase <= nxt_phase; state <= nxt_state; end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mreq_valid = (state == S_REQ);
  assign mreq_ext   = (int'(port) >= EXT_FIRST);
  assign mreq_phy   = phy_addr[int'(port)*AW +: AW];
  assign wr_en      = (state == S_WO) || (state == S_WT);
  assign wr_ovr     = (state == S_WO);
  assign wr_port    = port;
  assign wr_data    = (state == S_WO) ? ovr_q : tc_q;
  assign link_up    = link;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);

  assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |=> !mreq_valid);

  assert_tc_follows_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ovr) |-> ($past(wr_en) && $past(wr_ovr) && $past(wr_port) == wr_port));

  assert_tc_open_needs_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ovr && wr_data == 8'h00) |-> ($past(wr_data[0]) && $past(wr_data[6])));

  assert_link_rise_on_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_up & ~$past(link_up)) != '0) |-> $past(mrsp_valid));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_link_poller.sv
module sim_link_poller;
  logic clk = 0, rst_n = 0, start = 0, poll_req = 0;
  logic [7:0] port_en = '0, port_bypass = '0, force_fdx = '0;
  logic [15:0] force_spd = '0;
  logic [39:0] phy_addr;
  logic mreq_valid, mreq_ext, mrsp_valid = 0, wr_en, wr_ovr, busy, done;
  logic [4:0] mreq_phy, mreq_reg;
  logic [15:0] mrsp_data = '0;
  logic [2:0] wr_port;
  logic [7:0] wr_data, link_up;

  link_poller u0 (.clk(clk), .rst_n(rst_n), .start(start), .poll_req(poll_req),
    .port_en(port_en), .port_bypass(port_bypass), .force_spd(force_spd),
    .force_fdx(force_fdx), .phy_addr(phy_addr), .mreq_valid(mreq_valid),
    .mreq_ext(mreq_ext), .mreq_phy(mreq_phy), .mreq_reg(mreq_reg),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .wr_en(wr_en), .wr_ovr(wr_ovr),
    .wr_port(wr_port), .wr_data(wr_data), .link_up(link_up), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [15:0] m_live[8], m_latch[8], m_adv[8], m_lpa[8], m_c1k[8], m_s1k[8];
  bit tog[8];
  int rd_cnt[8];
  int ext_err = 0, overlap_err = 0, wr_cnt = 0, lat = 0, cnt = 0;
  bit pend = 0;
  logic [15:0] pval;
  logic [7:0] ovr_log[8], tc_log[8];
  logic [11:0] seq[64];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  always @(negedge clk) begin
    mrsp_valid = 0;
    if (pend) begin
      if (cnt == 0) begin mrsp_valid = 1; mrsp_data = pval; pend = 0; end
      else cnt--;
    end
    if (mreq_valid) begin
      int p;
      p = int'(mreq_phy) - 8;
      if (pend) overlap_err++;
      if (mreq_ext !== (p >= 4)) ext_err++;
      rd_cnt[p]++;
      case (mreq_reg)
        5'd1: begin pval = tog[p] ? m_live[p] : m_latch[p]; tog[p] = ~tog[p]; end
        5'd4: pval = m_adv[p];
        5'd5: pval = m_lpa[p];
        5'd9: pval = m_c1k[p];
        5'd10: pval = m_s1k[p];
        default: pval = 16'hDEAD;
      endcase
      pend = 1; cnt = lat; lat = (lat + 1) % 4;
    end
    if (wr_en) begin
      if (wr_cnt < 64) seq[wr_cnt] = {wr_ovr, wr_port, wr_data};
      wr_cnt++;
      if (wr_ovr) ovr_log[wr_port] = wr_data; else tc_log[wr_port] = wr_data;
    end
  end

  task automatic run(input bit full);
    for (int i = 0; i < 8; i++) begin rd_cnt[i] = 0; ovr_log[i] = 8'hEE; tc_log[i] = 8'hEE; end
    wr_cnt = 0;
    @(negedge clk);
    if (full) start = 1; else poll_req = 1;
    @(negedge clk);
    start = 0; poll_req = 0;
    do @(negedge clk); while (done !== 1'b1);
    @(negedge clk);
    check("R12 done is a single pulse", done, 0);
  endtask

  task automatic set_phy(input int p, input logic [15:0] live, input logic [15:0] adv,
                         input logic [15:0] lpa, input logic [15:0] c1k, input logic [15:0] s1k);
    m_live[p] = live; m_adv[p] = adv; m_lpa[p] = lpa; m_c1k[p] = c1k; m_s1k[p] = s1k;
    m_latch[p] = 16'h0000;
  endtask

  task automatic t_reset;
    check("R1 idle outputs", {busy, done, wr_en, mreq_valid}, 4'b0);
    check("R1 link_up cleared", link_up, 8'h00);
  endtask

  task automatic t_all_down;
    port_en = 8'hFF;
    for (int p = 0; p < 8; p++) begin
      set_phy(p, 16'h0000, 0, 0, 0, 0);
      m_latch[p] = 16'h0004;
    end
    run(1);
    check("R2 R5 only clearing writes", wr_cnt, 16);
    for (int k = 0; k < 8; k++) begin
      check("R2 override clear order", seq[2*k], {1'b1, 3'(k), 8'h40});
      check("R2 traffic clear order", seq[2*k+1], {1'b0, 3'(k), 8'h03});
      check("R4 two status reads", rd_cnt[k], 2);
    end
    check("R4 first read ignored", link_up, 8'h00);
  endtask

  task automatic t_mixed_up;
    port_en = 8'hFF; port_bypass = '0;
    set_phy(0, 16'h0004, 16'h01E1, 16'h01E1, 0, 0);
    set_phy(1, 16'h0004, 16'h01E1, 16'h0061, 0, 0);
    set_phy(2, 16'h0004, 16'h00A1, 16'h01E1, 0, 0);
    set_phy(3, 16'h0004, 16'h0141, 16'h00C1, 0, 0);
    set_phy(4, 16'h0104, 16'h01E1, 16'h01E1, 16'h0200, 16'h0800);
    set_phy(5, 16'h0104, 16'h01E1, 16'h01E1, 16'h0300, 16'h0400);
    set_phy(6, 16'h0104, 16'h01E1, 16'h01E1, 16'h0000, 16'h0C00);
    set_phy(7, 16'hFFFF, 0, 0, 0, 0);
    run(1);
    check("R7 R9 100 full", ovr_log[0], 8'h47);
    check("R7 R9 10 full", ovr_log[1], 8'h43);
    check("R7 R9 100 half", ovr_log[2], 8'h45);
    check("R7 priority 10 full over nothing", ovr_log[3], 8'h43);
    check("R8 gig full", ovr_log[4], 8'h4B);
    check("R8 gig half duplex from partner", ovr_log[5], 8'h49);
    check("R8 no local gig keeps 100", ovr_log[6], 8'h47);
    check("R4 all-ones skipped", {ovr_log[7], tc_log[7]}, {8'h40, 8'h03});
    for (int p = 0; p < 7; p++) check("R9 traffic opened", tc_log[p], 8'h00);
    check("R5 link_up", link_up, 8'h7F);
    check("R7 read count 10/100", rd_cnt[0], 4);
    check("R8 read count gig", rd_cnt[4], 6);
  endtask

  task automatic t_no_change;
    run(0);
    check("R5 no writes without change", wr_cnt, 0);
    check("R12 poll keeps link", link_up, 8'h7F);
  endtask

  task automatic t_drop;
    m_live[0] = 16'h0000;
    m_latch[0] = 16'h0004;
    run(0);
    check("R6 only dropped port written", wr_cnt, 2);
    check("R6 down override", ovr_log[0], 8'h40);
    check("R6 down traffic", tc_log[0], 8'h03);
    check("R5 link cleared", link_up, 8'h7E);
    check("R4 dropped port reads", rd_cnt[0], 2);
  endtask

  task automatic t_bypass;
    m_live[0] = 16'h0004;
    port_en = 8'h7F; port_bypass = 8'b0110_1100;
    force_spd = 16'b0001_0000_1110_0000;
    force_fdx = 8'b0010_0100;
    run(1);
    check("R3 forced 1000 full", ovr_log[2], 8'h4B);
    check("R3 invalid code no speed", ovr_log[3], 8'h41);
    check("R3 forced 10 full", ovr_log[5], 8'h43);
    check("R3 forced 100 half", ovr_log[6], 8'h45);
    check("R3 bypass traffic", {tc_log[2], tc_log[3], tc_log[5], tc_log[6]}, 32'h0);
    check("R3 bypass and disabled unread",
          rd_cnt[2] + rd_cnt[3] + rd_cnt[5] + rd_cnt[6] + rd_cnt[7], 0);
    check("R3 disabled port left cleared", {ovr_log[7], tc_log[7]}, {8'h40, 8'h03});
    check("R9 polled still resolved", {ovr_log[0], ovr_log[1], ovr_log[4]}, {8'h47, 8'h43, 8'h4B});
    check("R5 link only polled ports", link_up, 8'h13);
  endtask

  initial begin
    for (int p = 0; p < 8; p++) begin phy_addr[p*5 +: 5] = 5'(p + 8); tog[p] = 0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_all_down;
    t_mixed_up;
    t_no_change;
    t_drop;
    t_bypass;
    check("R10 bus select by port", ext_err, 0);
    check("R11 one read outstanding", overlap_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule